// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Sequencer

This block paces a small processor core. It splits the system clock into four rotating phases, T1 to T4, and one full rotation is one instruction cycle. It holds the program counter and drives it as the instruction-memory address. It latches the word returned by the memory at the end of each cycle and hands that word to the execute stage for the whole of the next cycle. Fetching the next word therefore overlaps executing the current one, and straight-line code completes one instruction per cycle.

When the executing instruction redirects control, the execute stage raises a branch request with a target address before the cycle ends. The sequencer loads the target, fetches it in the following cycle and discards the word that had already been fetched from the fall-through address. That cycle is an empty execute slot (a bubble). A registered sync output pulses once per cycle, aligned with T1, so other logic can lock to the instruction cycle.

Top module: `instr_cycle_seq`

## Requirements
- R1: Exactly one bit of `phase_strobe` is high at any time (bit 0 = T1, bit 3 = T4). The high bit moves T1→T2→T3→T4→T1 on every clock edge, so one instruction cycle is four clocks.
- R2: `imem_addr` equals the program counter. It changes only at the clock edge that ends T4, where it normally advances by one, and it holds steady for the remaining clocks of the cycle.
- R3: `imem_rdata` is sampled at the edge that ends T4. That word appears on `exec_word` with `exec_valid` high for the whole following instruction cycle, so straight-line code yields one valid word per cycle in address order.
- R4: If `branch_req` is high at the edge that ends T4 while `exec_valid` is high, the next cycle has `imem_addr` = `branch_target` and `exec_valid` low (a bubble). The cycle after that executes the word read from `branch_target`.
- R5: The program counter is `PC_W` bits wide (default 11, a 2048-word space) and wraps from 2^PC_W−1 to 0.
- R6: `t1_sync` is high for exactly one clock in every four, in the same clock as the T1 strobe (1:3 duty).
- R7: `branch_req` has no effect when `exec_valid` is low, or at any edge other than the one that ends T4. In both cases the program counter simply advances by one.
- R8: While `rst_n` is low, and immediately when it falls, the phase is T1, `imem_addr` is 0, `exec_valid` and `exec_word` are 0, and `t1_sync` is 1. After `rst_n` rises, the first phase advance happens on the third rising clock edge. `exec_valid` stays low for the whole first instruction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| imem_addr | output | PC_W | Instruction-memory address (program counter) |
| imem_rdata | input | IW | Instruction word read from `imem_addr` |
| phase_strobe | output | 4 | One-hot phase strobes, bit 0 = T1 … bit 3 = T4 |
| t1_sync | output | 1 | Registered once-per-cycle pulse aligned with T1 |
| exec_word | output | IW | Instruction word handed to the execute stage |
| exec_valid | output | 1 | `exec_word` is a real instruction this cycle |
| branch_req | input | 1 | Execute stage requests a control transfer |
| branch_target | input | PC_W | Address to transfer to |

## Verification
The bench goes after the cycle boundaries. A design that advanced the counter or latched the fetch word one clock early or late would show a skewed `imem_addr` or a stale `exec_word` in T1, and one that dropped the bubble would present the fall-through word as valid after a taken branch. It raises a branch request during a bubble and during T1 to T3 of a valid cycle: a design that honoured either would jump instead of advancing by one. It branches to the last address to catch a counter that saturates or fails to wrap. It also checks the reset values, the first empty execute cycle, and a mid-run asynchronous reset, where a design that waited for a clock edge would show stale outputs.

// File: rtl/icseq_pkg.sv
package icseq_pkg;

  localparam int unsigned NUM_PHASES = 4;

  typedef enum logic [1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_e;

endpackage

// File: rtl/icseq_rst_sync.sv
module icseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assertion is immediate; release ripples through STAGES flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/icseq_phase_gen.sv
module icseq_phase_gen
  import icseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [NUM_PHASES-1:0] strobe,
  output logic                  cycle_end,
  output logic                  sync_o
);

  phase_e ph_q, ph_d;
  logic   sync_q, sync_d;

  always_comb begin
    case (ph_q)
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3:   ph_d = PH_T4;
      default: ph_d = PH_T1;
    endcase
    sync_d = (ph_d == PH_T1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_T1;
      sync_q <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      sync_q <= sync_d;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_strobe
    localparam logic [1:0] CODE = 2'(g);
    assign strobe[g] = (ph_q == phase_e'(CODE));
  end

  assign cycle_end = (ph_q == PH_T4);
  assign sync_o    = sync_q;

endmodule

// File: rtl/icseq_pc_unit.sv
module icseq_pc_unit #(
  parameter int unsigned PC_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step_en,
  input  logic            load_en,
  input  logic [PC_W-1:0] load_addr,
  output logic [PC_W-1:0] pc
);

  logic [PC_W-1:0] pc_q, pc_d;

  // Modulo 2**PC_W increment: the carry out is simply dropped.
  always_comb begin
    pc_d = pc_q;
    if (step_en) begin
      pc_d = load_en ? load_addr : pc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_d;
    end
  end

  assign pc = pc_q;

endmodule

// File: rtl/icseq_fetch_reg.sv
module icseq_fetch_reg #(
  parameter int unsigned IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          kill,
  input  logic [IW-1:0] rdata,
  output logic [IW-1:0] word,
  output logic          valid
);

  logic [IW-1:0] word_q, word_d;
  logic          valid_q, valid_d;

  always_comb begin
    word_d  = word_q;
    valid_d = valid_q;
    if (cap_en) begin
      word_d  = rdata;
      valid_d = ~kill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word  = word_q;
  assign valid = valid_q;

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import icseq_pkg::*;
#(
  parameter int unsigned PC_W       = 11,
  parameter int unsigned IW         = 16,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [PC_W-1:0]       imem_addr,
  input  logic [IW-1:0]         imem_rdata,
  output logic [NUM_PHASES-1:0] phase_strobe,
  output logic                  t1_sync,
  output logic [IW-1:0]         exec_word,
  output logic                  exec_valid,
  input  logic                  branch_req,
  input  logic [PC_W-1:0]       branch_target
);

  logic rst_sync_n;
  logic cycle_end;
  logic take_branch;

  icseq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  icseq_phase_gen u_phase_gen (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .strobe    (phase_strobe),
    .cycle_end (cycle_end),
    .sync_o    (t1_sync)
  );

  // A request counts only at the edge closing T4 of a real instruction.
  assign take_branch = cycle_end & branch_req & exec_valid;

  icseq_pc_unit #(.PC_W(PC_W)) u_pc_unit (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step_en   (cycle_end),
    .load_en   (take_branch),
    .load_addr (branch_target),
    .pc        (imem_addr)
  );

  icseq_fetch_reg #(.IW(IW)) u_fetch_reg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cap_en (cycle_end),
    .kill   (take_branch),
    .rdata  (imem_rdata),
    .word   (exec_word),
    .valid  (exec_valid)
  );

endmodule

// File: rtl/instr_cycle_seq_chk.sv
module instr_cycle_seq_chk #(
  parameter int unsigned PC_W = 11,
  parameter int unsigned IW   = 16
) (
  input logic            clk,
  input logic            rst_ok,
  input logic [3:0]      strobe,
  input logic            t1_sync,
  input logic [PC_W-1:0] imem_addr,
  input logic [IW-1:0]   exec_word,
  input logic            exec_valid,
  input logic            branch_req,
  input logic [PC_W-1:0] branch_target
);

  logic [PC_W-1:0] addr_plus;
  assign addr_plus = imem_addr + 1'b1;

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    $countones(strobe) == 1);

  assert_phase_t1_t2_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    strobe[0] |=> strobe[1]);
  assert_phase_t2_t3_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    strobe[1] |=> strobe[2]);
  assert_phase_t3_t4_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    strobe[2] |=> strobe[3]);
  assert_phase_t4_t1_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    strobe[3] |=> strobe[0]);

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    !strobe[0] |-> $stable(imem_addr));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (strobe[3] && !(branch_req && exec_valid)) |=> (imem_addr == $past(addr_plus)));

  assert_exec_hold_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    !strobe[0] |-> ($stable(exec_word) && $stable(exec_valid)));

  assert_branch_load_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (strobe[3] && branch_req && exec_valid) |=>
      ((imem_addr == $past(branch_target)) && !exec_valid));

  assert_branch_ignored_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (strobe[3] && branch_req && !exec_valid) |=> (imem_addr == $past(addr_plus)));

  assert_sync_align_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    t1_sync == strobe[0]);

endmodule

bind instr_cycle_seq instr_cycle_seq_chk #(.PC_W(PC_W), .IW(IW)) u_chk (
  .clk           (clk),
  .rst_ok        (rst_sync_n),
  .strobe        (phase_strobe),
  .t1_sync       (t1_sync),
  .imem_addr     (imem_addr),
  .exec_word     (exec_word),
  .exec_valid    (exec_valid),
  .branch_req    (branch_req),
  .branch_target (branch_target)
);

// File: tb/test_instr_cycle_seq.sv
`timescale 1ns/1ps
module test_instr_cycle_seq;

  localparam int PC_W = 11;
  localparam int IW   = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PC_W-1:0] imem_addr;
  logic [IW-1:0]   imem_rdata;
  logic [3:0]      strobe;
  logic            t1_sync;
  logic [IW-1:0]   exec_word;
  logic            exec_valid;
  logic            br_req;
  logic [PC_W-1:0] br_tgt;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [IW-1:0] mem_fn(input logic [PC_W-1:0] a);
    return {a[4:0], a} ^ 16'h5A3C;
  endfunction

  assign imem_rdata = mem_fn(imem_addr);

  instr_cycle_seq #(.PC_W(PC_W), .IW(IW)) i_instr_cycle_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .imem_addr     (imem_addr),
    .imem_rdata    (imem_rdata),
    .phase_strobe  (strobe),
    .t1_sync       (t1_sync),
    .exec_word     (exec_word),
    .exec_valid    (exec_valid),
    .branch_req    (br_req),
    .branch_target (br_tgt)
  );

  // Reference model built from the requirements.
  logic [1:0]      m_rcnt;
  logic [1:0]      m_ph;
  logic [PC_W-1:0] m_pc;
  logic            m_exv;
  logic [IW-1:0]   m_exw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rcnt <= 2'd0; m_ph <= 2'd0; m_pc <= '0; m_exv <= 1'b0; m_exw <= '0;
    end else if (m_rcnt != 2'd2) begin
      m_rcnt <= m_rcnt + 2'd1;
    end else begin
      m_ph <= m_ph + 2'd1;
      if (m_ph == 2'd3) begin
        m_exw <= mem_fn(m_pc);
        m_exv <= !(br_req && m_exv);
        m_pc  <= (br_req && m_exv) ? br_tgt : m_pc + 1'b1;
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R1", "phase strobe", 32'(strobe), 32'(4'b0001 << m_ph));
      check("R6", "t1 sync", 32'(t1_sync), 32'(m_ph == 2'd0));
      check("R2", "fetch address", 32'(imem_addr), 32'(m_pc));
      check("R3", "exec valid", 32'(exec_valid), 32'(m_exv));
      if (m_exv) check("R3", "exec word", 32'(exec_word), 32'(m_exw));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int seed_val;
    int sync_cnt;
    seed_val = $urandom(32'd20240611);
    rst_n = 1'b0; br_req = 1'b0; br_tgt = '0;
    repeat (4) @(negedge clk);
    // R8 reset state
    check("R8", "reset strobe", 32'(strobe), 32'h1);
    check("R8", "reset sync", 32'(t1_sync), 32'h1);
    check("R8", "reset addr", 32'(imem_addr), 32'h0);
    check("R8", "reset valid", 32'(exec_valid), 32'h0);
    check("R8", "reset word", 32'(exec_word), 32'h0);
    cmp_on = 1'b1;
    rst_n = 1'b1;
    do @(negedge clk); while (!(m_rcnt == 2'd2 && m_ph == 2'd3));
    check("R8", "first cycle valid", 32'(exec_valid), 32'h0);

    // R4 / R5: branch to the last address, then wrap
    do @(negedge clk); while (!(m_ph == 2'd3 && m_exv));
    br_req = 1'b1; br_tgt = 11'h7FF;
    @(negedge clk);
    br_req = 1'b0;
    check("R4", "branch target fetched", 32'(imem_addr), 32'h7FF);
    check("R4", "bubble valid", 32'(exec_valid), 32'h0);
    // R7: request during the bubble is ignored
    do @(negedge clk); while (m_ph != 2'd3);
    br_req = 1'b1; br_tgt = 11'd5;
    @(negedge clk);
    br_req = 1'b0;
    check("R5", "wrap address", 32'(imem_addr), 32'h0);
    check("R4", "target valid", 32'(exec_valid), 32'h1);
    check("R4", "target word", 32'(exec_word), 32'(mem_fn(11'h7FF)));
    // R7: request outside T4 is ignored
    br_req = 1'b1; br_tgt = 11'd9;
    @(negedge clk);
    @(negedge clk);
    br_req = 1'b0;
    do @(negedge clk); while (m_ph != 2'd0);
    check("R7", "request outside T4", 32'(imem_addr), 32'h1);

    // R6: duty over ten cycles
    sync_cnt = 0;
    repeat (40) begin
      @(negedge clk);
      if (t1_sync) sync_cnt++;
    end
    check("R6", "sync pulses in 40 clocks", 32'(sync_cnt), 32'd10);

    // Random branch traffic
    repeat (4000) begin
      @(negedge clk);
      br_req = ($urandom_range(0, 5) == 0);
      br_tgt = PC_W'($urandom_range(0, 2047));
    end
    br_req = 1'b0;

    // R8: asynchronous reset mid-run
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    check("R8", "async strobe", 32'(strobe), 32'h1);
    check("R8", "async sync", 32'(t1_sync), 32'h1);
    check("R8", "async addr", 32'(imem_addr), 32'h0);
    check("R8", "async valid", 32'(exec_valid), 32'h0);
    check("R8", "async word", 32'(exec_word), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (24) @(negedge clk);
    report();
  end

endmodule